// File: doc/BRIEF.md
# SPI Buffer Level and Word-Count Tracker

This block keeps the bookkeeping for the byte buffers of one SPI channel. It does not hold the data bytes. It counts how many bytes sit in the transmit buffer and in the receive buffer. The host side and the shift engine move bytes with single-cycle push and pop strobes. The block compares both fill levels against thresholds that software programs, and drives a DMA read request and a DMA write request from those comparisons.

It also counts finished SPI words against a programmed total and flags when that total is reached. Three sticky event bits record an almost-empty crossing on the transmit side, an almost-full crossing on the receive side, and the end of the word count. Each event has its own enable, and the enabled events together drive a single interrupt line. Software reaches the thresholds, the word total, the events, the enables and the live levels through a small register port with a one-cycle write strobe and a combinational read.

Top module: `spi_ftrk_top`

## Requirements
- R1: While reset is asserted, both levels read zero, the empty flags are high, the full flags are low, irq is low and the enable register (address 3) reads zero.
- R2: An accepted push raises its buffer level by one and an accepted pop lowers it by one. A push and a pop in the same cycle leave the level unchanged. Address 4 returns the transmit level in bits [8:0] and the receive level in bits [24:16].
- R3: The full flag is high exactly when the level equals DEPTH (a build parameter of 16, 32, 64, 128 or 256), and the empty flag is high exactly when the level is zero. A push into a full buffer and a pop from an empty buffer are ignored and leave the level unchanged.
- R4: The threshold register is address 0. Bits [15:8] hold the almost-full value n-1. dmaRdReq is high exactly when the receive level is at least n.
- R5: Bits [7:0] of address 0 hold the almost-empty value n-1. dmaWrReq is high exactly when DEPTH minus the transmit level is at least n.
- R6: The status register is address 2. Bit 0 records transmit almost-empty, bit 1 records receive almost-full and bit 2 records end of word count. A bit sets one cycle after its condition becomes true and stays set until software writes 1 to it. Writing 0 to a bit leaves it unchanged. If an event fires in the same cycle as a clear, the event wins.
- R7: The word total is address 1, bits [15:0]. While chanEn is high, each wordDone pulse advances the word index. The pulse that completes the programmed number of words sets status bit 2 in the same clock edge and returns the index to zero. A total of 0 disables counting and never sets bit 2.
- R8: Reading address 1 returns the current word index while chanEn is high, and the programmed total while chanEn is low.
- R9: irq is the OR of the status bits ANDed with the enable bits (address 3, bits [2:0]), registered once, so it follows the status by one cycle.
- R10: While chanEn is low the word index is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| txPush | input | 1 | Host writes one byte into the transmit buffer |
| txPop | input | 1 | Shift engine takes one byte from the transmit buffer |
| rxPush | input | 1 | Shift engine stores one byte into the receive buffer |
| rxPop | input | 1 | Host reads one byte from the receive buffer |
| wordDone | input | 1 | Shift engine finished one SPI word |
| chanEn | input | 1 | Channel enabled |
| txFull | output | 1 | Transmit buffer full |
| txEmpty | output | 1 | Transmit buffer empty |
| rxFull | output | 1 | Receive buffer full |
| rxEmpty | output | 1 | Receive buffer empty |
| dmaRdReq | output | 1 | Receive almost-full request |
| dmaWrReq | output | 1 | Transmit almost-empty request |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach from the ports is a sticky event that fires again after software has cleared it. The events record only rising conditions, so a level that simply stays above its threshold never sets the bit again. The stimulus therefore pops the receive buffer below the almost-full level and pushes it back across. It then follows the status bit and the interrupt cycle by cycle through set, enable, clear and release. The buffer boundaries are reached by filling the transmit side to DEPTH and then pushing again, alone and together with a pop. The word counter is interrupted part-way through a count by dropping the channel enable.

// File: rtl/spi_ftrk_pkg.sv
package spi_ftrk_pkg;

  typedef struct packed {
    logic txInc;
    logic txDec;
    logic rxInc;
    logic rxDec;
  } lvlStrobe_t;

  localparam int unsigned EVT_NUM  = 3;
  localparam int unsigned EVT_TXAE = 0;
  localparam int unsigned EVT_RXAF = 1;
  localparam int unsigned EVT_EOW  = 2;

  localparam logic [2:0] ADDR_THRESH = 3'd0;
  localparam logic [2:0] ADDR_WCNT   = 3'd1;
  localparam logic [2:0] ADDR_STATUS = 3'd2;
  localparam logic [2:0] ADDR_ENABLE = 3'd3;
  localparam logic [2:0] ADDR_LEVEL  = 3'd4;

endpackage

// File: rtl/spi_ftrk_level.sv
module spi_ftrk_level #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             dec,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH)); // R3
  AST_NO_INC_FULL: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !inc); // R3
  AST_NO_DEC_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !dec); // R3

endmodule

// File: rtl/spi_ftrk_dp.sv
module spi_ftrk_dp
  import spi_ftrk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  lvlStrobe_t       strobe,
  input  logic [7:0]       aeThresh,
  input  logic [7:0]       afThresh,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  output logic             txFull,
  output logic             txEmpty,
  output logic             rxFull,
  output logic             rxEmpty,
  output logic             txWantData,
  output logic             rxHasData
);

  localparam int CMP_W = 10;

  logic [1:0]             incV, decV, fullV, emptyV;
  logic [1:0][LVL_W-1:0]  lvlV;

  assign incV = {strobe.rxInc, strobe.txInc};
  assign decV = {strobe.rxDec, strobe.txDec};

  for (genvar side = 0; side < 2; side++) begin : g_side
    spi_ftrk_level #(.DEPTH(DEPTH)) u_level (
      .clk   (clk),
      .rstN  (rstN),
      .inc   (incV[side]),
      .dec   (decV[side]),
      .level (lvlV[side]),
      .full  (fullV[side]),
      .empty (emptyV[side])
    );
  end

  assign txLevel = lvlV[0];
  assign rxLevel = lvlV[1];
  assign txFull  = fullV[0];
  assign rxFull  = fullV[1];
  assign txEmpty = emptyV[0];
  assign rxEmpty = emptyV[1];

  logic [CMP_W-1:0] txFree, aeNeed, afNeed;
  assign txFree = CMP_W'(DEPTH) - CMP_W'(txLevel);
  assign aeNeed = CMP_W'(aeThresh) + CMP_W'(1);
  assign afNeed = CMP_W'(afThresh) + CMP_W'(1);

  assign txWantData = (txFree >= aeNeed);
  assign rxHasData  = (CMP_W'(rxLevel) >= afNeed);

  AST_RDREQ_HAS_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    rxHasData |-> !rxEmpty); // R4
  AST_WRREQ_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    txWantData |-> !txFull); // R5

endmodule

// File: rtl/spi_ftrk_ctrl.sv
module spi_ftrk_ctrl
  import spi_ftrk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             wordDone,
  input  logic             chanEn,
  input  logic             txFull,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             rxEmpty,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             txWantData,
  input  logic             rxHasData,
  output lvlStrobe_t       strobe,
  output logic [7:0]       aeThresh,
  output logic [7:0]       afThresh,
  output logic             irq
);

  logic [15:0]        wcntProg;
  logic [15:0]        wordIdx;
  logic [EVT_NUM-1:0] status;
  logic [EVT_NUM-1:0] irqEnable;
  logic [1:0]         condPrev;
  logic [EVT_NUM-1:0] evtSet;
  logic [EVT_NUM-1:0] clrMask;
  logic               eowHit;
  logic               wrThresh, wrWcnt, wrStatus, wrEnable;
  logic               unusedWrBits;

  assign unusedWrBits = ^regWrData[31:16];

  assign strobe.txInc = txPush & ~txFull;
  assign strobe.txDec = txPop  & ~txEmpty;
  assign strobe.rxInc = rxPush & ~rxFull;
  assign strobe.rxDec = rxPop  & ~rxEmpty;

  assign wrThresh = regWrEn && (regAddr == ADDR_THRESH);
  assign wrWcnt   = regWrEn && (regAddr == ADDR_WCNT);
  assign wrStatus = regWrEn && (regAddr == ADDR_STATUS);
  assign wrEnable = regWrEn && (regAddr == ADDR_ENABLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aeThresh  <= '0;
      afThresh  <= '0;
      wcntProg  <= '0;
      irqEnable <= '0;
    end else begin
      if (wrThresh) begin
        aeThresh <= regWrData[7:0];
        afThresh <= regWrData[15:8];
      end
      if (wrWcnt)   wcntProg  <= regWrData[15:0];
      if (wrEnable) irqEnable <= regWrData[EVT_NUM-1:0];
    end
  end

  assign eowHit = chanEn && wordDone && (wcntProg != '0) &&
                  (wordIdx == wcntProg - 16'd1);

  always_ff @(posedge clk) begin
    if (!rstN || !chanEn) begin
      wordIdx <= '0;
    end else if (wordDone && (wcntProg != '0)) begin
      wordIdx <= eowHit ? '0 : wordIdx + 16'd1;
    end
  end

  always_comb begin
    evtSet           = '0;
    evtSet[EVT_TXAE] = txWantData & ~condPrev[0];
    evtSet[EVT_RXAF] = rxHasData  & ~condPrev[1];
    evtSet[EVT_EOW]  = eowHit;
    clrMask          = wrStatus ? regWrData[EVT_NUM-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condPrev <= '0;
      status   <= '0;
      irq      <= 1'b0;
    end else begin
      condPrev <= {rxHasData, txWantData};
      status   <= (status & ~clrMask) | evtSet;
      irq      <= |(status & irqEnable);
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_THRESH: regRdData[15:0] = {afThresh, aeThresh};
      ADDR_WCNT:   regRdData[15:0] = chanEn ? wordIdx : wcntProg;
      ADDR_STATUS: regRdData[EVT_NUM-1:0] = status;
      ADDR_ENABLE: regRdData[EVT_NUM-1:0] = irqEnable;
      ADDR_LEVEL: begin
        regRdData[8:0]   = 9'(txLevel);
        regRdData[24:16] = 9'(rxLevel);
      end
      default: regRdData = '0;
    endcase
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !wrStatus |=> ((status & $past(status)) == $past(status))); // R6
  AST_EOW_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    eowHit |=> (wordIdx == '0) && status[EVT_EOW]); // R7
  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> (wordIdx == '0)); // R10
  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(irqEnable) != '0)); // R9

endmodule

// File: rtl/spi_ftrk_top.sv
module spi_ftrk_top
  import spi_ftrk_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        txPush,
  input  logic        txPop,
  input  logic        rxPush,
  input  logic        rxPop,
  input  logic        wordDone,
  input  logic        chanEn,
  output logic        txFull,
  output logic        txEmpty,
  output logic        rxFull,
  output logic        rxEmpty,
  output logic        dmaRdReq,
  output logic        dmaWrReq,
  output logic        irq
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  initial begin
    AST_DEPTH_LEGAL: assert (DEPTH == 16 || DEPTH == 32 || DEPTH == 64 ||
                             DEPTH == 128 || DEPTH == 256); // R3
  end

  lvlStrobe_t       strobe;
  logic [7:0]       aeThresh, afThresh;
  logic [LVL_W-1:0] txLevel, rxLevel;
  logic             txWantData, rxHasData;

  spi_ftrk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .txPush     (txPush),
    .txPop      (txPop),
    .rxPush     (rxPush),
    .rxPop      (rxPop),
    .wordDone   (wordDone),
    .chanEn     (chanEn),
    .txFull     (txFull),
    .txEmpty    (txEmpty),
    .rxFull     (rxFull),
    .rxEmpty    (rxEmpty),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .txWantData (txWantData),
    .rxHasData  (rxHasData),
    .strobe     (strobe),
    .aeThresh   (aeThresh),
    .afThresh   (afThresh),
    .irq        (irq)
  );

  spi_ftrk_dp #(.DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .aeThresh   (aeThresh),
    .afThresh   (afThresh),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .txFull     (txFull),
    .txEmpty    (txEmpty),
    .rxFull     (rxFull),
    .rxEmpty    (rxEmpty),
    .txWantData (txWantData),
    .rxHasData  (rxHasData)
  );

  assign dmaRdReq = rxHasData;
  assign dmaWrReq = txWantData;

endmodule

// File: tb/spi_ftrk_top_bench.sv
module spi_ftrk_top_bench;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [4:0]  ops = '0;  // {txPush, txPop, rxPush, rxPop, wordDone}
  logic        chanEn = 1'b0;
  logic        txFull, txEmpty, rxFull, rxEmpty, dmaRdReq, dmaWrReq, irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_ftrk_top #(.DEPTH(DEPTH)) u_spi_ftrk_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .txPush(ops[4]), .txPop(ops[3]), .rxPush(ops[2]), .rxPop(ops[1]),
    .wordDone(ops[0]), .chanEn(chanEn),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .dmaRdReq(dmaRdReq), .dmaWrReq(dmaWrReq), .irq(irq)
  );

  // {txPush, txPop, rxPush, rxPop, expected tx level, expected rx level}
  localparam logic [13:0] VEC [0:7] = '{
    {4'b1010, 5'd1, 5'd1},
    {4'b1010, 5'd2, 5'd2},
    {4'b1101, 5'd2, 5'd1},
    {4'b0101, 5'd1, 5'd0},
    {4'b0101, 5'd0, 5'd0},
    {4'b0110, 5'd0, 5'd1},
    {4'b1000, 5'd1, 5'd1},
    {4'b0001, 5'd1, 5'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doOps(input logic [4:0] o);
    ops = o;
    tick();
    ops = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flags", {28'd0, txFull, txEmpty, rxFull, rxEmpty}, 32'b0101);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(3'd4, r); chk("R1 levels", r, 32'd0);
    rd(3'd3, r); chk("R1 enable", r, 32'd0);
    rstN = 1'b1;
    tick(); tick();
    rd(3'd2, r); chk("R6 txae after reset", r, 32'd1);

    // R2 / R3 table walk
    for (int i = 0; i < 8; i++) begin
      doOps({VEC[i][13:10], 1'b0});
      rd(3'd4, r);
      chk("R2 R3 table levels", r, {7'd0, 4'd0, VEC[i][4:0], 7'd0, 4'd0, VEC[i][9:5]});
    end

    // R3 fill transmit side to DEPTH
    for (int i = 0; i < 15; i++) doOps(5'b10000);
    chk("R3 txFull", {31'd0, txFull}, 32'd1);
    doOps(5'b10000);
    rd(3'd4, r); chk("R3 push on full ignored", r[8:0], 32'd16);
    doOps(5'b11000);
    rd(3'd4, r); chk("R3 push+pop on full", r[8:0], 32'd15);

    // R4 / R5 thresholds: almost-full n=4, almost-empty n=5
    wr(3'd0, 32'h0304);
    chk("R5 wrreq free1", {31'd0, dmaWrReq}, 32'd0);
    for (int i = 0; i < 3; i++) doOps(5'b01000);
    chk("R5 wrreq free4", {31'd0, dmaWrReq}, 32'd0);
    doOps(5'b01000);
    chk("R5 wrreq free5", {31'd0, dmaWrReq}, 32'd1);
    for (int i = 0; i < 3; i++) doOps(5'b00100);
    chk("R4 rdreq level3", {31'd0, dmaRdReq}, 32'd0);
    doOps(5'b00100);
    chk("R4 rdreq level4", {31'd0, dmaRdReq}, 32'd1);
    tick();

    // R6 sticky / write-1-clear
    rd(3'd2, r); chk("R6 both pending", r, 32'd3);
    wr(3'd2, 32'd0);
    rd(3'd2, r); chk("R6 write 0 keeps", r, 32'd3);
    wr(3'd2, 32'd2);
    rd(3'd2, r); chk("R6 clear bit1 only", r, 32'd1);
    wr(3'd2, 32'd1);
    rd(3'd2, r); chk("R6 clear bit0, no refire on steady level", r, 32'd0);

    // R9 interrupt timing
    wr(3'd3, 32'd2);
    doOps(5'b00010);
    doOps(5'b00100);
    rd(3'd2, r); chk("R6 not yet set", r, 32'd0);
    tick();
    rd(3'd2, r); chk("R6 set after crossing", r, 32'd2);
    chk("R9 irq lags status", {31'd0, irq}, 32'd0);
    tick();
    chk("R9 irq raised", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'd2);
    chk("R9 irq one cycle after clear", {31'd0, irq}, 32'd1);
    tick();
    chk("R9 irq dropped", {31'd0, irq}, 32'd0);

    // R7 / R8 word count
    wr(3'd1, 32'd3);
    chanEn = 1'b1;
    rd(3'd1, r); chk("R8 index while enabled", r, 32'd0);
    doOps(5'b00001); doOps(5'b00001);
    rd(3'd1, r); chk("R8 index after two words", r, 32'd2);
    rd(3'd2, r); chk("R7 no eow early", r & 32'd4, 32'd0);
    doOps(5'b00001);
    rd(3'd2, r); chk("R7 eow set", r & 32'd4, 32'd4);
    rd(3'd1, r); chk("R7 index wraps", r, 32'd0);
    chanEn = 1'b0;
    rd(3'd1, r); chk("R8 programmed total when idle", r, 32'd3);
    wr(3'd2, 32'd4);
    wr(3'd1, 32'd0);
    chanEn = 1'b1;
    for (int i = 0; i < 3; i++) doOps(5'b00001);
    rd(3'd2, r); chk("R7 zero total disables", r & 32'd4, 32'd0);
    rd(3'd1, r); chk("R7 zero total index", r, 32'd0);

    // R10 index cleared by disable
    chanEn = 1'b0;
    wr(3'd1, 32'd5);
    chanEn = 1'b1;
    doOps(5'b00001); doOps(5'b00001);
    rd(3'd1, r); chk("R10 index mid count", r, 32'd2);
    chanEn = 1'b0;
    tick();
    chanEn = 1'b1;
    rd(3'd1, r); chk("R10 index cleared", r, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule